// File: doc/BRIEF.md
# Phase-Shifted Dual H-Bridge Modulator

This block produces the gate commands for two full H-bridges, a primary and a secondary, that sit on either side of an isolation transformer. Both bridges share one switching period, counted in clock cycles. Each bridge has its own duty count, which shapes a three-level AC voltage of +V, 0 and −V. The secondary waveform runs a programmable number of cycles behind the primary, and that delay sets the power flow between the two DC buses.

Each bridge has a zero-state decoder that decides which transistor pair carries each zero interval: both upper switches or both lower switches. The pair can be fixed, or it can alternate with the polarity of the pulse that came before. A single-active-bridge mode commands only one bridge and holds the other fully off. A power-sign input picks which bridge is active.

All settings are captured into shadow registers at a period boundary, so a waveform never changes in the middle of a period. The block has no dead-time insertion and no closed-loop regulation.

Top module: `dhb_modulator`

## Requirements
- R1: While `rst` is high, all eight gate outputs are 0 and every setting input is captured. In the first cycle after `rst` falls, both bridges run from position 0 of a period with the captured settings.
- R2: Period length is P cycles and the position c runs 0..P−1, with H = P/2. Within a half period, the pulse occupies the positions h where s ≤ h < s+D, with s = (H−D)/2 (integer division) and h the position inside that half. In the first half the pulse is +V, encoded gate = 4'b1001. In the second half it is −V, encoded 4'b0110. Gate bit 0 is T1 (upper left), bit 1 is T2 (lower left), bit 2 is T3 (upper right) and bit 3 is T4 (lower right).
- R3: A duty of D = H gives a pure square wave that alternates between +V and −V with no zero state. A duty of D = 0 gives only zero states.
- R4: A zero state is either upper-pair (4'b0101) or lower-pair (4'b1010). A zero follows +V when it lies after the pulse in the first half or before the pulse in the second half; otherwise it follows −V. The 2-bit decoder code selects the pair: 0 gives upper after +V and lower after −V; 1 gives upper always; 2 gives lower always; 3 gives lower after +V and upper after −V.
- R5: In dual mode the secondary bridge uses the position (c − phase) mod P, so its waveform is delayed by `phase` cycles.
- R6: A new period, duty, phase, decoder, mode or sign value takes effect only at position 0 of the period that follows the period in which it is presented. The block captures it in the cycle at position P−1.
- R7: With `sab_en_i` = 1 and `pwr_pos_i` = 1, the primary bridge runs and the secondary gates are 0000. With `pwr_pos_i` = 0, the secondary bridge runs at zero phase with its own duty and decoder, and the primary gates are 0000.
- R8: Inputs are sanitised at capture. Bit 0 of the period is ignored, and a period below 4 becomes 4. A duty above H becomes H. A phase of P or more becomes 0.
- R9: In either bridge, T1 and T2 are never on together, and T3 and T4 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 12 | Switching period in cycles |
| duty_pri_i | input | 12 | Primary pulse length per half period |
| duty_sec_i | input | 12 | Secondary pulse length per half period |
| phase_i | input | 12 | Secondary delay in cycles |
| zdec_pri_i | input | 2 | Primary zero-state decoder code |
| zdec_sec_i | input | 2 | Secondary zero-state decoder code |
| sab_en_i | input | 1 | Single-active-bridge mode |
| pwr_pos_i | input | 1 | Power sign, 1 = positive |
| gate_pri_o | output | 4 | Primary gates {T4,T3,T2,T1} |
| gate_sec_o | output | 4 | Secondary gates {T4,T3,T2,T1} |

## Verification
A wrong position counter or a wrong shadow capture moves pulse edges. That shows at the gate ports within one period, and it appears either as a pulse shifted by some cycles or as a setting applied one period early. A wrong zero-pair decision shows at the first zero interval after the faulty pulse. The bench compares both gate nibbles against an independent model in every cycle, so a fault is seen in the cycle it first affects the outputs.

// File: rtl/dhb_pkg.sv
package dhb_pkg;

    parameter int CNT_W   = 12;
    parameter int MIN_PER = 4;

    typedef enum logic [1:0] {
        ZD_TOP_BOT = 2'd0,
        ZD_TOP     = 2'd1,
        ZD_BOT     = 2'd2,
        ZD_BOT_TOP = 2'd3
    } zdec_e;

    typedef enum logic [1:0] {
        LV_ZERO_AFTER_POS = 2'd0,
        LV_ZERO_AFTER_NEG = 2'd1,
        LV_POS            = 2'd2,
        LV_NEG            = 2'd3
    } level_e;

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty_pri;
        logic [CNT_W-1:0] duty_sec;
        logic [CNT_W-1:0] phase;
        zdec_e            zdec_pri;
        zdec_e            zdec_sec;
        logic             sab;
        logic             pos;
    } cfg_t;

    localparam logic [3:0] G_POS  = 4'b1001;
    localparam logic [3:0] G_NEG  = 4'b0110;
    localparam logic [3:0] G_ZTOP = 4'b0101;
    localparam logic [3:0] G_ZBOT = 4'b1010;

    function automatic logic [3:0] gates_of(level_e lv, zdec_e dec);
        logic after_pos;
        logic use_top;
        after_pos = (lv == LV_ZERO_AFTER_POS);
        unique case (dec)
            ZD_TOP_BOT: use_top = after_pos;
            ZD_TOP:     use_top = 1'b1;
            ZD_BOT:     use_top = 1'b0;
            default:    use_top = !after_pos;
        endcase
        unique case (lv)
            LV_POS:  return G_POS;
            LV_NEG:  return G_NEG;
            default: return use_top ? G_ZTOP : G_ZBOT;
        endcase
    endfunction

endpackage

// File: rtl/dhb_timebase.sv
module dhb_timebase
    import dhb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_in,
    output logic [CNT_W-1:0] cnt_o,
    output cfg_t             cfg_o
);
    localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PER);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    cfg_t             clean;
    logic [CNT_W-1:0] per_even;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg_q;
    logic             at_end;

    always_comb begin
        clean    = cfg_in;
        per_even = {cfg_in.per[CNT_W-1:1], 1'b0};
        clean.per = (per_even < PER_FLOOR) ? PER_FLOOR : per_even;
        half     = clean.per >> 1;
        if (cfg_in.duty_pri > half) clean.duty_pri = half;
        if (cfg_in.duty_sec > half) clean.duty_sec = half;
        if (cfg_in.phase >= clean.per) clean.phase = '0;
    end

    assign at_end = (cnt_q == cfg_q.per - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cfg_q <= clean;
        end else if (at_end) begin
            cnt_q <= '0;
            cfg_q <= clean;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;
    assign cfg_o = cfg_q;

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q < cfg_q.per);
    assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == cfg_q.per - ONE) |=> (cnt_q == '0));
    assert_cfg_held_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != cfg_q.per - ONE) |=> $stable(cfg_q));
    assert_duty_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.duty_pri <= (cfg_q.per >> 1)) && (cfg_q.duty_sec <= (cfg_q.per >> 1)));

endmodule

// File: rtl/dhb_level_gen.sv
module dhb_level_gen
    import dhb_pkg::*;
(
    input  logic [CNT_W-1:0] pos_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] duty_i,
    output level_e           level_o
);
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] h;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    logic             second;

    always_comb begin
        half   = per_i >> 1;
        second = (pos_i >= half);
        h      = second ? (pos_i - half) : pos_i;
        lo     = (half - duty_i) >> 1;
        hi     = lo + duty_i;
        if (h >= lo && h < hi)
            level_o = second ? LV_NEG : LV_POS;
        else if (second)
            level_o = (h < lo) ? LV_ZERO_AFTER_POS : LV_ZERO_AFTER_NEG;
        else
            level_o = (h >= hi) ? LV_ZERO_AFTER_POS : LV_ZERO_AFTER_NEG;
    end

endmodule

// File: rtl/dhb_modulator.sv
module dhb_modulator
    import dhb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_pri_i,
    input  logic [CNT_W-1:0] duty_sec_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [1:0]       zdec_pri_i,
    input  logic [1:0]       zdec_sec_i,
    input  logic             sab_en_i,
    input  logic             pwr_pos_i,
    output logic [3:0]       gate_pri_o,
    output logic [3:0]       gate_sec_o
);
    localparam int NB = 2;

    cfg_t             cfg_in;
    cfg_t             cfg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pos   [NB];
    logic [CNT_W-1:0] duty  [NB];
    zdec_e            dec   [NB];
    logic             run   [NB];
    logic [3:0]       gates [NB];

    always_comb begin
        cfg_in.per      = period_i;
        cfg_in.duty_pri = duty_pri_i;
        cfg_in.duty_sec = duty_sec_i;
        cfg_in.phase    = phase_i;
        cfg_in.zdec_pri = zdec_e'(zdec_pri_i);
        cfg_in.zdec_sec = zdec_e'(zdec_sec_i);
        cfg_in.sab      = sab_en_i;
        cfg_in.pos      = pwr_pos_i;
    end

    dhb_timebase u_tb (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cnt_o  (cnt),
        .cfg_o  (cfg)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bridge
            level_e lvl;
            if (b == 0) begin : g_pri
                assign pos[b]  = cnt;
                assign duty[b] = cfg.duty_pri;
                assign dec[b]  = cfg.zdec_pri;
                assign run[b]  = !cfg.sab || cfg.pos;
            end else begin : g_sec
                assign pos[b]  = (cfg.sab || cnt >= cfg.phase) ?
                                 (cnt - (cfg.sab ? '0 : cfg.phase)) :
                                 ((cfg.per - cfg.phase) + cnt);
                assign duty[b] = cfg.duty_sec;
                assign dec[b]  = cfg.zdec_sec;
                assign run[b]  = !cfg.sab || !cfg.pos;
            end

            dhb_level_gen u_lvl (
                .pos_i   (pos[b]),
                .per_i   (cfg.per),
                .duty_i  (duty[b]),
                .level_o (lvl)
            );

            assign gates[b] = (rst || !run[b]) ? 4'b0000 : gates_of(lvl, dec[b]);
        end
    endgenerate

    assign gate_pri_o = gates[0];
    assign gate_sec_o = gates[1];

    assert_leg_exclusive_R9: assert property (@(posedge clk)
        !(gate_pri_o[0] && gate_pri_o[1]) && !(gate_pri_o[2] && gate_pri_o[3]) &&
        !(gate_sec_o[0] && gate_sec_o[1]) && !(gate_sec_o[2] && gate_sec_o[3]));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> (gate_pri_o == 4'b0000 && gate_sec_o == 4'b0000));
    assert_passive_off_R7: assert property (@(posedge clk) disable iff (rst)
        cfg.sab |-> (cfg.pos ? (gate_sec_o == 4'b0000) : (gate_pri_o == 4'b0000)));
    assert_sec_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
        pos[1] < cfg.per);

endmodule

// File: tb/dhb_modulator_bench.sv
`timescale 1ns/1ps
module dhb_modulator_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] period_i = 12'd16;
    logic [11:0] duty_pri_i = 12'd8;
    logic [11:0] duty_sec_i = 12'd8;
    logic [11:0] phase_i = 12'd0;
    logic [1:0]  zdec_pri_i = 2'd0;
    logic [1:0]  zdec_sec_i = 2'd0;
    logic        sab_en_i = 1'b0;
    logic        pwr_pos_i = 1'b1;
    logic [3:0]  gate_pri_o;
    logic [3:0]  gate_sec_o;

    always #2.5 clk = ~clk;

    dhb_modulator u_dhb_modulator (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .duty_pri_i (duty_pri_i),
        .duty_sec_i (duty_sec_i),
        .phase_i    (phase_i),
        .zdec_pri_i (zdec_pri_i),
        .zdec_sec_i (zdec_sec_i),
        .sab_en_i   (sab_en_i),
        .pwr_pos_i  (pwr_pos_i),
        .gate_pri_o (gate_pri_o),
        .gate_sec_o (gate_sec_o)
    );

    typedef struct {
        logic [3:0] pri;
        logic [3:0] sec;
        string      req;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // model state
    int m_cnt = 0, m_per = 4, m_dp = 0, m_ds = 0, m_ph = 0, m_zp = 0, m_zs = 0;
    bit m_sab = 0, m_pos = 1;

    function automatic logic [3:0] model_gate(int c, int p, int d, int zd);
        int  hh, h, lo, hi;
        bit  second, after_pos, top;
        hh = p / 2;
        second = (c >= hh);
        h = second ? c - hh : c;
        lo = (hh - d) / 2;
        hi = lo + d;
        if (h >= lo && h < hi) return second ? 4'b0110 : 4'b1001;
        after_pos = second ? (h < lo) : (h >= hi);
        case (zd)
            0: top = after_pos;
            1: top = 1'b1;
            2: top = 1'b0;
            default: top = !after_pos;
        endcase
        return top ? 4'b0101 : 4'b1010;
    endfunction

    task automatic model_load();
        int p;
        p = int'(period_i) & ~1;
        if (p < 4) p = 4;
        m_per = p;
        m_dp = (int'(duty_pri_i) > p / 2) ? p / 2 : int'(duty_pri_i);
        m_ds = (int'(duty_sec_i) > p / 2) ? p / 2 : int'(duty_sec_i);
        m_ph = (int'(phase_i) >= p) ? 0 : int'(phase_i);
        m_zp = int'(zdec_pri_i);
        m_zs = int'(zdec_sec_i);
        m_sab = sab_en_i;
        m_pos = pwr_pos_i;
    endtask

    // predictor: follows the requirements, pushes one expected item per cycle
    initial begin
        forever begin
            @(posedge clk);
            if (rst) begin
                m_cnt = 0;
                model_load();
            end else if (m_cnt == m_per - 1) begin
                m_cnt = 0;
                model_load();
            end else begin
                m_cnt = m_cnt + 1;
            end
            #2;
            begin
                exp_t e;
                int   sp;
                e.req = cur_req;
                if (rst) begin
                    e.pri = 4'b0000;
                    e.sec = 4'b0000;
                end else begin
                    sp = m_sab ? m_cnt : (m_cnt - m_ph + m_per) % m_per;
                    e.pri = (!m_sab || m_pos) ? model_gate(m_cnt, m_per, m_dp, m_zp) : 4'b0000;
                    e.sec = (!m_sab || !m_pos) ? model_gate(sp, m_per, m_ds, m_zs) : 4'b0000;
                end
                sb_q.push_back(e);
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (gate_pri_o !== e.pri || gate_sec_o !== e.sec) begin
                errors++;
                $display("FAIL %s: gates pri=%b sec=%b expected pri=%b sec=%b",
                         e.req, gate_pri_o, gate_sec_o, e.pri, e.sec);
            end
            checks++;
            if ((gate_pri_o[0] && gate_pri_o[1]) || (gate_pri_o[2] && gate_pri_o[3]) ||
                (gate_sec_o[0] && gate_sec_o[1]) || (gate_sec_o[2] && gate_sec_o[3])) begin
                errors++;
                $display("FAIL R9: leg overlap pri=%b sec=%b expected no pair on", gate_pri_o, gate_sec_o);
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(int per, int dp, int ds, int ph, int zp, int zs, bit sab, bit pos);
        period_i   = 12'(per);
        duty_pri_i = 12'(dp);
        duty_sec_i = 12'(ds);
        phase_i    = 12'(ph);
        zdec_pri_i = 2'(zp);
        zdec_sec_i = 2'(zs);
        sab_en_i   = sab;
        pwr_pos_i  = pos;
    endtask

    initial begin
        #0.1;
        cur_req = "R1";
        set_cfg(16, 8, 8, 0, 0, 0, 0, 1);
        cycles(4);
        rst = 1'b0;
        cur_req = "R3";          // square wave, D = H, R2 polarity
        cycles(40);
        cur_req = "R2";          // quarter duty, centred pulses
        set_cfg(16, 4, 4, 0, 0, 0, 0, 1);
        cycles(40);
        cur_req = "R4";          // every decoder code on each bridge
        for (int d = 0; d < 4; d++) begin
            set_cfg(20, 3, 6, 0, d, 3 - d, 0, 1);
            cycles(45);
        end
        cur_req = "R3";          // zero duty
        set_cfg(12, 0, 0, 0, 1, 2, 0, 1);
        cycles(30);
        cur_req = "R5";          // phase shift
        set_cfg(16, 6, 4, 5, 0, 3, 0, 1);
        cycles(40);
        set_cfg(24, 12, 12, 17, 0, 0, 0, 1);
        cycles(55);
        cur_req = "R6";          // change mid-period repeatedly
        for (int k = 0; k < 6; k++) begin
            set_cfg(10 + 2 * k, k, 5 - k, k, k % 4, (k + 1) % 4, 0, 1);
            cycles(7);
        end
        cycles(30);
        cur_req = "R7";          // single-active-bridge, both signs
        set_cfg(16, 5, 7, 3, 0, 0, 1, 1);
        cycles(40);
        set_cfg(16, 5, 7, 3, 3, 1, 1, 0);
        cycles(40);
        cur_req = "R8";          // sanitising
        set_cfg(15, 30, 9, 15, 0, 0, 0, 1);
        cycles(40);
        set_cfg(1, 3, 1, 7, 1, 0, 0, 1);
        cycles(20);
        cur_req = "R1";          // reset mid-run
        set_cfg(18, 4, 9, 2, 0, 0, 0, 1);
        rst = 1'b1;
        cycles(5);
        rst = 1'b0;
        cycles(40);
        done = 1;
        cycles(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule